// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block sits behind the register file of a hot-plug capable bridge and turns one written command byte, with a 5-bit target slot number, into updates of per-slot state. Each slot keeps a 2-bit state (power only, enabled or disabled), a power indicator and an attention indicator. It also keeps a latch-open flag, a 2-bit presence field and three latched event bits. One packed byte carries the requested slot state and both indicator settings. The block enforces which state transitions are legal. When a slot is switched off with its power indicator dark, the block marks the slot empty.

Software issues a command by putting the code and the target on the command inputs and pulsing the write strobe for one cycle. Single-slot commands, bus-speed commands and rejected commands finish at the clock edge that takes the strobe. The two group commands visit the slots one per clock and report busy until the last slot has been visited. Every command, including a rejected one, clears the previous error bits and sets a command-done flag when it finishes. After reset the block spends one cycle loading each slot from its presence input.

Top module: `hpc_cmd_ctrl`

## Requirements
- R1: After reset, a slot whose presence input is high is enabled (state 2) with power indicator on (1), latch closed and presence field 0. Every other slot is disabled (state 3) with power indicator off (3), latch open and presence field 3. All attention indicators, event bits, error bits, the done flag and the bus speed read 0, and busy (status bit 0) is low.
- R2: Codes 0x00–0x3F address one slot. Bits [1:0] give the requested state (0 keep, 1 power only, 2 enabled, 3 disabled), bits [3:2] the power indicator and bits [5:4] the attention indicator (0 keep, 1 on, 2 blink, 3 off). A nonzero indicator field is written into the slot and a zero field leaves it as it was.
- R3: A single-slot command whose target is 0, or whose target minus one is not below the slot count, sets the invalid-command bit (status bit 2) and changes no slot.
- R4: A request for power only on an enabled slot sets status bit 2 and leaves that slot's state and both indicators unchanged.
- R5: A disabled slot may move to power only or to enabled. An enabled or power-only slot may move to disabled. Every other state request leaves the state as it was, while the indicator fields still apply.
- R6: When a move to disabled leaves the power indicator off, the slot's latch-open flag is set, its presence field becomes 3, and all three of its event bits (bit 0 presence, bit 1 button, bit 2 latch) are set.
- R7: Codes 0x40–0x47 select the bus speed from bits [2:0]. Speed 0 is accepted. Any other speed sets the invalid-mode bit (status bit 3) and leaves the speed unchanged.
- R8: Code 0x48 (power all) and code 0x49 (enable all) are rejected with status bit 2 when any slot is enabled, and no slot changes.
- R9: Otherwise a group command visits the slots in ascending order, one per clock. A slot with its latch closed gets the group's state (1 for 0x48, 2 for 0x49) under the R5 rules, and its power indicator goes on. A slot with its latch open keeps its state, and its power indicator goes off. Busy stays high for exactly the slot-count cycles.
- R10: Each accepted strobe first clears status bits 0–3. Codes 0x4A–0xFF set status bit 2. Status bit 1 always reads 0.
- R11: The done flag is cleared when a command is launched and set when it finishes, whether it succeeded or not. It stays low during a group sweep and rises at the edge that ends the sweep.
- R12: A strobe given while busy is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | One-cycle command strobe |
| cmd_code_i | input | 8 | Command code |
| cmd_target_i | input | 5 | Target slot number, 1-based |
| slot_present_i | input | NSLOTS | Slot occupied at reset |
| cmd_status_o | output | 4 | {invalid mode, invalid command, 0, busy} |
| cmd_detected_o | output | 1 | Command-done flag |
| bus_speed_o | output | 3 | Selected bus speed |
| slot_state_o | output | 2*NSLOTS | Per-slot state, slot i at [2i+1:2i] |
| slot_pwr_ind_o | output | 2*NSLOTS | Per-slot power indicator |
| slot_attn_ind_o | output | 2*NSLOTS | Per-slot attention indicator |
| slot_latch_open_o | output | NSLOTS | Per-slot latch-open flag |
| slot_presence_o | output | 2*NSLOTS | Per-slot presence field |
| slot_events_o | output | 3*NSLOTS | Per-slot event bits, slot i at [3i+2:3i] |

## Verification
The hardest situation to reach is a group sweep that does real work. It needs no slot to be enabled, a mix of open and closed latches, and a slot that already sits in power only, so that enable-all hits a forbidden transition. The bench builds this from the ports alone. It empties one present slot by disabling it with the power indicator off, disables the other present slot while its indicator stays on, and only then issues power-all followed by enable-all. In the middle of the first sweep it fires an extra command at an open-latch slot and then checks that the slot's attention indicator never moved.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef enum logic [1:0] {
    SS_KEEP = 2'd0,
    SS_PWR  = 2'd1,
    SS_EN   = 2'd2,
    SS_DIS  = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    IND_KEEP  = 2'd0,
    IND_ON    = 2'd1,
    IND_BLINK = 2'd2,
    IND_OFF   = 2'd3
  } ind_e;

  typedef enum logic [2:0] {
    CK_SLOT,
    CK_SPEED,
    CK_PWR_ALL,
    CK_EN_ALL,
    CK_BAD
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SQ_INIT,
    SQ_IDLE,
    SQ_SWEEP
  } seq_st_e;

  localparam logic [1:0] PRES_LOW   = 2'd0;
  localparam logic [1:0] PRES_EMPTY = 2'd3;
  localparam logic [7:0] CODE_PWR_ALL = 8'h48;
  localparam logic [7:0] CODE_EN_ALL  = 8'h49;

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
  import hpc_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_kind_e  kind_o,
  output slot_st_e   state_o,
  output ind_e       pwr_o,
  output ind_e       attn_o,
  output logic [2:0] speed_o
);

  always_comb begin
    state_o = slot_st_e'(code_i[1:0]);
    pwr_o   = ind_e'(code_i[3:2]);
    attn_o  = ind_e'(code_i[5:4]);
    speed_o = code_i[2:0];
    if (code_i[7:6] == 2'b00) begin
      kind_o = CK_SLOT;
    end else if (code_i[7:3] == 5'b01000) begin
      kind_o = CK_SPEED;
    end else if (code_i == CODE_PWR_ALL) begin
      kind_o = CK_PWR_ALL;
    end else if (code_i == CODE_EN_ALL) begin
      kind_o = CK_EN_ALL;
    end else begin
      kind_o = CK_BAD;
    end
  end

endmodule

// File: rtl/hpc_slot_unit.sv
module hpc_slot_unit
  import hpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_i,
  input  logic       present_i,
  input  logic       apply_i,
  input  slot_st_e   req_state_i,
  input  ind_e       req_pwr_i,
  input  ind_e       req_attn_i,
  output slot_st_e   state_o,
  output ind_e       pwr_o,
  output ind_e       attn_o,
  output logic       latch_o,
  output logic [1:0] pres_o,
  output logic [2:0] evt_o
);

  slot_st_e   state_q, state_d;
  ind_e       pwr_q, pwr_d;
  ind_e       attn_q, attn_d;
  logic       latch_q, latch_d;
  logic [1:0] pres_q, pres_d;
  logic [2:0] evt_q, evt_d;

  always_comb begin
    state_d = state_q;
    pwr_d   = pwr_q;
    attn_d  = attn_q;
    latch_d = latch_q;
    pres_d  = pres_q;
    evt_d   = evt_q;
    if (init_i) begin
      if (present_i) begin
        state_d = SS_EN;
        pwr_d   = IND_ON;
        latch_d = 1'b0;
        pres_d  = PRES_LOW;
      end
    end else if (apply_i) begin
      if (req_pwr_i != IND_KEEP) pwr_d = req_pwr_i;
      if (req_attn_i != IND_KEEP) attn_d = req_attn_i;
      if (state_q == SS_DIS && (req_state_i == SS_PWR || req_state_i == SS_EN)) begin
        state_d = req_state_i;
      end else if ((state_q == SS_EN || state_q == SS_PWR) && req_state_i == SS_DIS) begin
        state_d = SS_DIS;
        if (pwr_d == IND_OFF) begin
          latch_d = 1'b1;
          pres_d  = PRES_EMPTY;
          evt_d   = evt_q | 3'b111;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_DIS;
      pwr_q   <= IND_OFF;
      attn_q  <= IND_KEEP;
      latch_q <= 1'b1;
      pres_q  <= PRES_EMPTY;
      evt_q   <= 3'b000;
    end else if (init_i || apply_i) begin
      state_q <= state_d;
      pwr_q   <= pwr_d;
      attn_q  <= attn_d;
      latch_q <= latch_d;
      pres_q  <= pres_d;
      evt_q   <= evt_d;
    end
  end

  assign state_o = state_q;
  assign pwr_o   = pwr_q;
  assign attn_o  = attn_q;
  assign latch_o = latch_q;
  assign pres_o  = pres_q;
  assign evt_o   = evt_q;

  AST_NO_ILLEGAL_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply_i && state_q == SS_EN && req_state_i == SS_PWR)); // R4

  AST_HOLD_WITHOUT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply_i && !init_i) |=> $stable(state_q)); // R5

  AST_EVENTS_NEED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != 3'b000) |-> latch_q); // R6

endmodule

// File: rtl/hpc_sequencer.sv
module hpc_sequencer
  import hpc_pkg::*;
#(
  parameter int NSLOTS = 8,
  localparam int IW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr_i,
  input  cmd_kind_e             kind_i,
  input  slot_st_e              dec_state_i,
  input  ind_e                  dec_pwr_i,
  input  ind_e                  dec_attn_i,
  input  logic [2:0]            dec_speed_i,
  input  logic [4:0]            target_i,
  input  logic [2*NSLOTS-1:0]   state_vec_i,
  input  logic [NSLOTS-1:0]     latch_vec_i,
  output logic                  init_o,
  output logic                  apply_o,
  output logic [IW-1:0]         idx_o,
  output slot_st_e              req_state_o,
  output ind_e                  req_pwr_o,
  output ind_e                  req_attn_o,
  output logic [3:0]            status_o,
  output logic                  detected_o,
  output logic [2:0]            speed_o
);

  seq_st_e     fsm_q, fsm_d;
  logic [IW-1:0] idx_q, idx_d;
  logic        grp_en_q, grp_en_d;
  logic        err_cmd_q, err_cmd_d;
  logic        err_mode_q, err_mode_d;
  logic        det_q, det_d;
  logic [2:0]  speed_q, speed_d;

  logic        tgt_ok;
  logic [IW-1:0] tgt_idx;
  slot_st_e    tgt_state;
  logic        any_en;
  logic        sweep_latch;

  assign tgt_ok  = (target_i != 5'd0) && ({1'b0, target_i} <= 6'(NSLOTS));
  assign tgt_idx = IW'(target_i - 5'd1);

  always_comb begin
    tgt_state   = SS_KEEP;
    any_en      = 1'b0;
    sweep_latch = 1'b0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (5'(i) == target_i - 5'd1) tgt_state = slot_st_e'(state_vec_i[2*i +: 2]);
      if (state_vec_i[2*i +: 2] == 2'(SS_EN)) any_en = 1'b1;
      if (IW'(i) == idx_q) sweep_latch = latch_vec_i[i];
    end
  end

  always_comb begin
    fsm_d       = fsm_q;
    idx_d       = idx_q;
    grp_en_d    = grp_en_q;
    err_cmd_d   = err_cmd_q;
    err_mode_d  = err_mode_q;
    det_d       = det_q;
    speed_d     = speed_q;
    init_o      = 1'b0;
    apply_o     = 1'b0;
    idx_o       = idx_q;
    req_state_o = dec_state_i;
    req_pwr_o   = dec_pwr_i;
    req_attn_o  = dec_attn_i;
    case (fsm_q)
      SQ_INIT: begin
        init_o = 1'b1;
        fsm_d  = SQ_IDLE;
      end
      SQ_IDLE: begin
        idx_o = tgt_idx;
        if (cmd_wr_i) begin
          err_cmd_d  = 1'b0;
          err_mode_d = 1'b0;
          det_d      = 1'b1;
          case (kind_i)
            CK_SLOT: begin
              if (!tgt_ok || (tgt_state == SS_EN && dec_state_i == SS_PWR)) begin
                err_cmd_d = 1'b1;
              end else begin
                apply_o = 1'b1;
              end
            end
            CK_SPEED: begin
              if (dec_speed_i == 3'd0) speed_d = dec_speed_i;
              else err_mode_d = 1'b1;
            end
            CK_PWR_ALL, CK_EN_ALL: begin
              if (any_en) begin
                err_cmd_d = 1'b1;
              end else begin
                fsm_d    = SQ_SWEEP;
                idx_d    = '0;
                grp_en_d = (kind_i == CK_EN_ALL);
                det_d    = 1'b0;
              end
            end
            default: err_cmd_d = 1'b1;
          endcase
        end
      end
      SQ_SWEEP: begin
        apply_o     = 1'b1;
        req_state_o = sweep_latch ? SS_KEEP : (grp_en_q ? SS_EN : SS_PWR);
        req_pwr_o   = sweep_latch ? IND_OFF : IND_ON;
        req_attn_o  = IND_KEEP;
        if (idx_q == IW'(NSLOTS - 1)) begin
          fsm_d = SQ_IDLE;
          det_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: fsm_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q      <= SQ_INIT;
      idx_q      <= '0;
      grp_en_q   <= 1'b0;
      err_cmd_q  <= 1'b0;
      err_mode_q <= 1'b0;
      det_q      <= 1'b0;
      speed_q    <= 3'd0;
    end else begin
      fsm_q      <= fsm_d;
      idx_q      <= idx_d;
      grp_en_q   <= grp_en_d;
      err_cmd_q  <= err_cmd_d;
      err_mode_q <= err_mode_d;
      det_q      <= det_d;
      speed_q    <= speed_d;
    end
  end

  assign status_o   = {err_mode_q, err_cmd_q, 1'b0, (fsm_q != SQ_IDLE)};
  assign detected_o = det_q;
  assign speed_o    = speed_q;

  AST_SWEEP_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == SQ_SWEEP) |-> (32'(idx_q) < NSLOTS)); // R9

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q) |-> (fsm_q == SQ_IDLE)); // R11

  AST_ONE_ERROR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err_mode_q, err_cmd_q}) <= 1); // R10

  AST_SWEEP_IGNORES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == SQ_SWEEP) |=> $stable({err_mode_q, err_cmd_q})); // R12

endmodule

// File: rtl/hpc_cmd_ctrl.sv
module hpc_cmd_ctrl
  import hpc_pkg::*;
#(
  parameter int NSLOTS = 8,
  localparam int IW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr_i,
  input  logic [7:0]            cmd_code_i,
  input  logic [4:0]            cmd_target_i,
  input  logic [NSLOTS-1:0]     slot_present_i,
  output logic [3:0]            cmd_status_o,
  output logic                  cmd_detected_o,
  output logic [2:0]            bus_speed_o,
  output logic [2*NSLOTS-1:0]   slot_state_o,
  output logic [2*NSLOTS-1:0]   slot_pwr_ind_o,
  output logic [2*NSLOTS-1:0]   slot_attn_ind_o,
  output logic [NSLOTS-1:0]     slot_latch_open_o,
  output logic [2*NSLOTS-1:0]   slot_presence_o,
  output logic [3*NSLOTS-1:0]   slot_events_o
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cmd_kind_e  dec_kind;
  slot_st_e   dec_state;
  ind_e       dec_pwr, dec_attn;
  logic [2:0] dec_speed;

  hpc_cmd_decode u_dec (
    .code_i  (cmd_code_i),
    .kind_o  (dec_kind),
    .state_o (dec_state),
    .pwr_o   (dec_pwr),
    .attn_o  (dec_attn),
    .speed_o (dec_speed)
  );

  logic          seq_init, seq_apply;
  logic [IW-1:0] seq_idx;
  slot_st_e      req_state;
  ind_e          req_pwr, req_attn;

  hpc_sequencer #(.NSLOTS(NSLOTS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cmd_wr_i    (cmd_wr_i),
    .kind_i      (dec_kind),
    .dec_state_i (dec_state),
    .dec_pwr_i   (dec_pwr),
    .dec_attn_i  (dec_attn),
    .dec_speed_i (dec_speed),
    .target_i    (cmd_target_i),
    .state_vec_i (slot_state_o),
    .latch_vec_i (slot_latch_open_o),
    .init_o      (seq_init),
    .apply_o     (seq_apply),
    .idx_o       (seq_idx),
    .req_state_o (req_state),
    .req_pwr_o   (req_pwr),
    .req_attn_o  (req_attn),
    .status_o    (cmd_status_o),
    .detected_o  (cmd_detected_o),
    .speed_o     (bus_speed_o)
  );

  for (genvar gi = 0; gi < NSLOTS; gi++) begin : g_slot
    slot_st_e st;
    ind_e     pw, at;

    hpc_slot_unit u_slot (
      .clk         (clk),
      .rst_n       (rst_sync_q),
      .init_i      (seq_init),
      .present_i   (slot_present_i[gi]),
      .apply_i     (seq_apply && (seq_idx == IW'(gi))),
      .req_state_i (req_state),
      .req_pwr_i   (req_pwr),
      .req_attn_i  (req_attn),
      .state_o     (st),
      .pwr_o       (pw),
      .attn_o      (at),
      .latch_o     (slot_latch_open_o[gi]),
      .pres_o      (slot_presence_o[2*gi +: 2]),
      .evt_o       (slot_events_o[3*gi +: 3])
    );

    assign slot_state_o[2*gi +: 2]    = st;
    assign slot_pwr_ind_o[2*gi +: 2]  = pw;
    assign slot_attn_ind_o[2*gi +: 2] = at;
  end

endmodule

// File: tb/hpc_cmd_ctrl_test.sv
module hpc_cmd_ctrl_test;

  localparam int N = 5;
  localparam time CLK_PERIOD = 10ns;

  logic           clk, rst_n, cmd_wr;
  logic [7:0]     cmd_code;
  logic [4:0]     cmd_target;
  logic [N-1:0]   present;
  logic [3:0]     status;
  logic           detected;
  logic [2:0]     speed;
  logic [2*N-1:0] st_v, pw_v, at_v, pr_v;
  logic [N-1:0]   la_v;
  logic [3*N-1:0] ev_v;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  hpc_cmd_ctrl #(.NSLOTS(N)) uut (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd_wr_i          (cmd_wr),
    .cmd_code_i        (cmd_code),
    .cmd_target_i      (cmd_target),
    .slot_present_i    (present),
    .cmd_status_o      (status),
    .cmd_detected_o    (detected),
    .bus_speed_o       (speed),
    .slot_state_o      (st_v),
    .slot_pwr_ind_o    (pw_v),
    .slot_attn_ind_o   (at_v),
    .slot_latch_open_o (la_v),
    .slot_presence_o   (pr_v),
    .slot_events_o     (ev_v)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [1:0] st(int i); return st_v[2*i +: 2]; endfunction
  function automatic logic [1:0] pw(int i); return pw_v[2*i +: 2]; endfunction
  function automatic logic [1:0] at(int i); return at_v[2*i +: 2]; endfunction
  function automatic logic [1:0] pr(int i); return pr_v[2*i +: 2]; endfunction
  function automatic logic [2:0] ev(int i); return ev_v[3*i +: 3]; endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] code, input logic [4:0] tgt);
    @(negedge clk);
    cmd_code   = code;
    cmd_target = tgt;
    cmd_wr     = 1'b1;
    @(negedge clk);
    cmd_wr     = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    check("R1 slot0 state", st(0), 2);
    check("R1 slot0 pwr", pw(0), 1);
    check("R1 slot0 latch", la_v[0], 0);
    check("R1 slot0 presence", pr(0), 0);
    check("R1 slot2 state", st(2), 2);
    check("R1 slot1 state", st(1), 3);
    check("R1 slot1 pwr", pw(1), 3);
    check("R1 slot1 latch", la_v[1], 1);
    check("R1 slot3 presence", pr(3), 3);
    check("R1 attention all", at_v, 0);
    check("R1 events all", ev_v, 0);
    check("R1 status", status, 0);
    check("R1 detected", detected, 0);
    check("R1 speed", speed, 0);
  endtask

  task automatic t_decode();
    send(8'h26, 5'd2);
    check("R2 slot1 state enabled", st(1), 2);
    check("R2 slot1 pwr on", pw(1), 1);
    check("R2 slot1 attn blink", at(1), 2);
    check("R2 status", status, 0);
    check("R11 detected single", detected, 1);
    send(8'h30, 5'd2);
    check("R2 slot1 state kept", st(1), 2);
    check("R2 slot1 pwr kept", pw(1), 1);
    check("R2 slot1 attn off", at(1), 3);
  endtask

  task automatic t_illegal();
    send(8'h0D, 5'd2);
    check("R4 status invalid", status, 4);
    check("R4 slot1 state", st(1), 2);
    check("R4 slot1 pwr", pw(1), 1);
    check("R4 slot1 attn", at(1), 3);
    check("R11 detected on failure", detected, 1);
  endtask

  task automatic t_range();
    logic [2*N-1:0] s0, p0;
    s0 = st_v; p0 = pw_v;
    send(8'h04, 5'd0);
    check("R3 target zero status", status, 4);
    check("R3 target zero states", st_v, s0);
    check("R3 target zero pwr", pw_v, p0);
    send(8'h04, 5'd6);
    check("R3 target high status", status, 4);
    check("R3 target high pwr", pw_v, p0);
    send(8'h08, 5'd5);
    check("R3 last slot accepted", status, 0);
    check("R3 last slot pwr blink", pw(4), 2);
  endtask

  task automatic t_transition();
    send(8'h0B, 5'd2);
    check("R5 enabled to disabled", st(1), 3);
    check("R5 pwr blink", pw(1), 2);
    check("R6 no empty when lit", ev(1), 0);
    send(8'h03, 5'd4);
    check("R5 disabled stays", st(3), 3);
    check("R6 no events from disabled", ev(3), 0);
    send(8'h01, 5'd2);
    check("R5 disabled to power only", st(1), 1);
    send(8'h02, 5'd2);
    check("R5 power only to enabled refused", st(1), 1);
    check("R5 refused not an error", status, 0);
    send(8'h03, 5'd2);
    check("R5 power only to disabled", st(1), 3);
  endtask

  task automatic t_empty();
    send(8'h0F, 5'd1);
    check("R6 slot0 disabled", st(0), 3);
    check("R6 slot0 pwr off", pw(0), 3);
    check("R6 slot0 latch open", la_v[0], 1);
    check("R6 slot0 presence empty", pr(0), 3);
    check("R6 slot0 events", ev(0), 7);
  endtask

  task automatic t_speed_unknown();
    send(8'h40, 5'd0);
    check("R7 speed zero accepted", status, 0);
    check("R7 speed value", speed, 0);
    send(8'h45, 5'd0);
    check("R7 bad speed", status, 8);
    check("R7 speed kept", speed, 0);
    send(8'h4A, 5'd0);
    check("R10 unknown 4A", status, 4);
    send(8'hFF, 5'd0);
    check("R10 unknown FF", status, 4);
    send(8'h40, 5'd0);
    check("R10 status cleared", status, 0);
  endtask

  task automatic t_group_abort();
    logic [2*N-1:0] p0;
    p0 = pw_v;
    send(8'h49, 5'd0);
    check("R8 enable all aborted", status, 4);
    check("R8 detected", detected, 1);
    send(8'h48, 5'd0);
    check("R8 power all aborted", status, 4);
    check("R8 slot2 state", st(2), 2);
    check("R8 pwr unchanged", pw_v, p0);
  endtask

  task automatic t_group();
    int cnt;
    send(8'h03, 5'd3);
    check("R5 slot2 disabled lit", st(2), 3);
    check("R6 slot2 latch closed", la_v[2], 0);
    send(8'h48, 5'd0);
    cnt = 0;
    while (status[0] && cnt < 100) begin
      cnt++;
      if (cnt == 1) check("R11 detected low in sweep", detected, 0);
      if (cnt == 2) begin
        cmd_code = 8'h30; cmd_target = 5'd5; cmd_wr = 1'b1;
      end else begin
        cmd_wr = 1'b0;
      end
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    check("R9 busy cycles", cnt, N);
    check("R11 detected after sweep", detected, 1);
    check("R9 status", status, 0);
    check("R9 slot2 power only", st(2), 1);
    check("R9 slot2 pwr on", pw(2), 1);
    check("R9 slot0 state kept", st(0), 3);
    check("R9 slot4 pwr off", pw(4), 3);
    check("R9 slot1 pwr off", pw(1), 3);
    check("R12 strobe while busy ignored", at(4), 0);
    send(8'h49, 5'd0);
    cnt = 0;
    while (status[0] && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check("R9 enable sweep cycles", cnt, N);
    check("R9 slot2 stays power only", st(2), 1);
    check("R9 slot3 state kept", st(3), 3);
    check("R9 events unchanged", ev_v, 15'h0007);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_code = 8'h00; cmd_target = 5'd0;
    present = 5'b00101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_decode();
    t_illegal();
    t_range();
    t_transition();
    t_empty();
    t_speed_unknown();
    t_group_abort();
    t_group();
    summary();
  end

endmodule